// File: doc/BRIEF.md
# SPI Flash Command Shift Engine

This block is a register-driven SPI master. It issues one serial-flash command frame for each start request. Software loads three registers through a simple word-wide port:

- a command word, holding the opcode byte and a 24-bit flash address;
- a 32-bit data word;
- a control word, holding a transmit byte count, a receive byte count and a start bit.

On start, the engine drops chip select and shifts out the transmit bytes. It then clocks in the receive bytes and packs them into the data word. Afterwards it releases chip select, waits one SCK period, clears busy and pulses done for one clock.

The link is strictly half duplex. Every transmit byte leaves before the first receive bit is sampled. SCK runs in SPI mode 0: it idles low, outgoing data changes after the falling edge, and incoming data is sampled on the rising edge. The SCK half period is a parameter, `SCK_HALF_DIV`, counted in system clocks.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, `spi_cs_no` is 1, `spi_sck_o`, `spi_mosi_o` and `done_o` are 0, and all three registers read 0.
- R2: The register index on `reg_addr_i` selects a register, and reads are combinational:
  - 0 is the command word: opcode in bits 7:0, flash address in bits 31:8.
  - 1 is the data word.
  - 2 is control: transmit count in bits 3:0, receive count in bits 6:4, start in bit 8 (write only) and busy in bit 31 (read only). The counts read back are the ones latched at the last start.
- R3: A control write with bit 8 set while idle sets busy and lowers chip select at the next clock edge. The frame then carries (tx+rx)*8 bits. Each bit holds SCK low for `SCK_HALF_DIV` clocks and then high for `SCK_HALF_DIV` clocks, and SCK is never high while chip select is high.
- R4: Transmit byte k is taken from a fixed slot:
  - k=0 is command bits 7:0.
  - k=1..3 are command bits 31:24, 23:16 and 15:8, in that order.
  - k=4..7 are data bits 7:0, 15:8, 23:16 and 31:24, in that order.
  Each byte goes out MSB first. MOSI holds steady while SCK is high and is 0 outside transmit bits.
- R5: MISO is sampled only on SCK rising edges after the last transmit bit. Receive byte j, MSB first, lands in data bits 8j+7:8j, and unreceived bytes read 0. With a receive count of 0 the data word is left unchanged.
- R6: At start, a transmit count of 0 becomes 1 and a transmit count above 8 becomes 8. A receive count above 4 becomes 4.
- R7: While busy, every register write is dropped, including one carrying start.
- R8: A control write without bit 8 leaves the latched counts unchanged.
- R9: Chip select rises at the falling SCK edge that ends the last bit. It stays high for 2*`SCK_HALF_DIV` clocks while busy. Then busy falls, the data word updates and `done_o` is high for exactly one clock, all at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| spi_sck_o | output | 1 | SPI clock, mode 0 |
| spi_cs_no | output | 1 | Chip select, active low |
| spi_mosi_o | output | 1 | Serial data to flash |
| spi_miso_i | input | 1 | Serial data from flash |
| done_o | output | 1 | One-clock frame-complete pulse |

## Verification
Take the start write's clock edge as t=0. Chip select and busy change at that edge, and SCK rises at t=2bD+D for bit b, where D is the half period. Chip select returns high at t=2ND, and busy, done and the received data word all change at t=2ND+2D. A behavioural model in the bench tracks t and recomputes the expected pins and read data after every edge. The outputs are sampled a quarter period after each rising edge. Register read-backs use literal values derived from the requirements, and MISO is driven from the model's bit position on falling clock edges, so every sampled bit is stable at its rising SCK edge.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    localparam int unsigned WORD_W       = 32;
    localparam int unsigned MAX_TX_BYTES = 8;
    localparam int unsigned MAX_RX_BYTES = 4;
    localparam int unsigned TXC_W        = $clog2(MAX_TX_BYTES + 1);
    localparam int unsigned RXC_W        = $clog2(MAX_RX_BYTES + 1);
    localparam int unsigned BIT_W        = $clog2((MAX_TX_BYTES + MAX_RX_BYTES) * 8 + 1);
    localparam int unsigned RXI_W        = $clog2(MAX_RX_BYTES * 8);
    localparam int unsigned KIDX_W       = BIT_W - 3;

    localparam logic [1:0] REG_CMD  = 2'd0;
    localparam logic [1:0] REG_DATA = 2'd1;
    localparam logic [1:0] REG_CTRL = 2'd2;

    localparam int unsigned CTL_TX_LSB = 0;
    localparam int unsigned CTL_RX_LSB = 4;
    localparam int unsigned CTL_START  = 8;
    localparam int unsigned CTL_BUSY   = 31;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_SHIFT = 2'd1,
        SEQ_GAP   = 2'd2
    } seq_state_e;
endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
    import spi_cmd_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [1:0]        addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o,
    input  logic              busy_i,
    input  logic              rx_load_i,
    input  logic [WORD_W-1:0] rx_word_i,
    output logic [WORD_W-1:0] cmd_o,
    output logic [WORD_W-1:0] data_o,
    output logic [TXC_W-1:0]  tx_cnt_o,
    output logic [RXC_W-1:0]  rx_cnt_o,
    output logic              start_o
);
    typedef struct packed {
        logic [WORD_W-1:0] cmd;
        logic [WORD_W-1:0] data;
        logic [TXC_W-1:0]  tx;
        logic [RXC_W-1:0]  rx;
    } regs_t;

    regs_t reg_d, reg_q;
    logic  start_d;

    function automatic logic [TXC_W-1:0] fit_tx(input logic [TXC_W-1:0] v);
        if (v == '0) return TXC_W'(1);
        if (v > TXC_W'(MAX_TX_BYTES)) return TXC_W'(MAX_TX_BYTES);
        return v;
    endfunction

    function automatic logic [RXC_W-1:0] fit_rx(input logic [RXC_W-1:0] v);
        if (v > RXC_W'(MAX_RX_BYTES)) return RXC_W'(MAX_RX_BYTES);
        return v;
    endfunction

    always_comb begin
        reg_d   = reg_q;
        start_d = 1'b0;
        if (we_i && !busy_i) begin
            case (addr_i)
                REG_CMD:  reg_d.cmd  = wdata_i;
                REG_DATA: reg_d.data = wdata_i;
                REG_CTRL: begin
                    if (wdata_i[CTL_START]) begin
                        start_d  = 1'b1;
                        reg_d.tx = fit_tx(wdata_i[CTL_TX_LSB +: TXC_W]);
                        reg_d.rx = fit_rx(wdata_i[CTL_RX_LSB +: RXC_W]);
                    end
                end
                default: ;
            endcase
        end
        if (rx_load_i && reg_q.rx != '0) begin
            reg_d.data = rx_word_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) reg_q <= '0;
        else         reg_q <= reg_d;
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            REG_CMD:  rdata_o = reg_q.cmd;
            REG_DATA: rdata_o = reg_q.data;
            REG_CTRL: begin
                rdata_o[CTL_TX_LSB +: TXC_W] = reg_q.tx;
                rdata_o[CTL_RX_LSB +: RXC_W] = reg_q.rx;
                rdata_o[CTL_BUSY]            = busy_i;
            end
            default: rdata_o = '0;
        endcase
    end

    assign cmd_o    = reg_q.cmd;
    assign data_o   = reg_q.data;
    assign tx_cnt_o = reg_q.tx;
    assign rx_cnt_o = reg_q.rx;
    assign start_o  = start_d;

    // R7
    busy_write_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_i && we_i) |=> ($stable(reg_q.cmd) && $stable(reg_q.tx) && $stable(reg_q.rx)));

    // R8
    count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == REG_CTRL && !wdata_i[CTL_START]) |=> ($stable(reg_q.tx) && $stable(reg_q.rx)));
endmodule

// File: rtl/spi_cmd_tick.sv
module spi_cmd_tick #(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic active_i,
    output logic tick_o
);
    localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!active_i)              cnt_d = '0;
        else if (cnt_q == CNT_LAST) cnt_d = '0;
        else                        cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign tick_o = active_i && (cnt_q == CNT_LAST);

    // R3
    half_period_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q <= CNT_LAST));
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_cmd_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              tick_i,
    input  logic [TXC_W-1:0]  tx_cnt_i,
    input  logic [RXC_W-1:0]  rx_cnt_i,
    input  logic [WORD_W-1:0] cmd_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic              miso_i,
    output logic              busy_o,
    output logic              sck_o,
    output logic              cs_n_o,
    output logic              mosi_o,
    output logic              done_o,
    output logic              rx_load_o,
    output logic [WORD_W-1:0] rx_word_o
);
    typedef struct packed {
        seq_state_e        st;
        logic [BIT_W-1:0]  bit_idx;
        logic              sck;
        logic              cs_n;
        logic              gap_half;
        logic              done;
        logic [WORD_W-1:0] rx_word;
    } seq_t;

    localparam seq_t SEQ_RESET = '{st: SEQ_IDLE, bit_idx: '0, sck: 1'b0, cs_n: 1'b1,
                                   gap_half: 1'b0, done: 1'b0, rx_word: '0};

    seq_t seq_d, seq_q;

    logic [BIT_W-1:0] tx_bits, total_bits, rx_rel;
    logic [RXI_W-1:0] rx_pos;
    logic             load_d;

    function automatic logic [7:0] stream_byte(input logic [KIDX_W-1:0] k,
                                               input logic [WORD_W-1:0] c,
                                               input logic [WORD_W-1:0] d);
        case (k)
            KIDX_W'(0): return c[7:0];
            KIDX_W'(1): return c[31:24];
            KIDX_W'(2): return c[23:16];
            KIDX_W'(3): return c[15:8];
            default:    return d[{k[1:0], 3'b000} +: 8];
        endcase
    endfunction

    assign tx_bits    = BIT_W'(tx_cnt_i) << 3;
    assign total_bits = (BIT_W'(tx_cnt_i) + BIT_W'(rx_cnt_i)) << 3;
    assign rx_rel     = seq_q.bit_idx - tx_bits;
    assign rx_pos     = RXI_W'(rx_rel) ^ RXI_W'(7);

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        load_d     = 1'b0;
        case (seq_q.st)
            SEQ_IDLE: begin
                if (start_i) begin
                    seq_d.st       = SEQ_SHIFT;
                    seq_d.bit_idx  = '0;
                    seq_d.sck      = 1'b0;
                    seq_d.cs_n     = 1'b0;
                    seq_d.gap_half = 1'b0;
                    seq_d.rx_word  = '0;
                end
            end
            SEQ_SHIFT: begin
                if (tick_i) begin
                    if (!seq_q.sck) begin
                        seq_d.sck = 1'b1;
                        if (seq_q.bit_idx >= tx_bits) begin
                            seq_d.rx_word[rx_pos] = miso_i;
                        end
                    end else begin
                        seq_d.sck = 1'b0;
                        if (seq_q.bit_idx == total_bits - BIT_W'(1)) begin
                            seq_d.st       = SEQ_GAP;
                            seq_d.cs_n     = 1'b1;
                            seq_d.gap_half = 1'b0;
                        end else begin
                            seq_d.bit_idx = seq_q.bit_idx + BIT_W'(1);
                        end
                    end
                end
            end
            SEQ_GAP: begin
                if (tick_i) begin
                    if (!seq_q.gap_half) begin
                        seq_d.gap_half = 1'b1;
                    end else begin
                        seq_d.st   = SEQ_IDLE;
                        seq_d.done = 1'b1;
                        load_d     = 1'b1;
                    end
                end
            end
            default: seq_d = SEQ_RESET;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seq_q <= SEQ_RESET;
        else         seq_q <= seq_d;
    end

    always_comb begin
        mosi_o = 1'b0;
        if (seq_q.st == SEQ_SHIFT && seq_q.bit_idx < tx_bits) begin
            mosi_o = stream_byte(seq_q.bit_idx[BIT_W-1:3], cmd_i, data_i)[~seq_q.bit_idx[2:0]];
        end
    end

    assign busy_o    = (seq_q.st != SEQ_IDLE);
    assign sck_o     = seq_q.sck;
    assign cs_n_o    = seq_q.cs_n;
    assign done_o    = seq_q.done;
    assign rx_load_o = load_d;
    assign rx_word_o = seq_q.rx_word;

    // R3
    sck_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_q.sck |-> !seq_q.cs_n);

    // R4
    mosi_steady_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.sck && $past(seq_q.sck)) |-> $stable(mosi_o));

    // R9
    done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_q.done |=> !seq_q.done);

    // R9
    done_busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_q.done |-> (!busy_o && $past(busy_o)));

    // R9
    cs_gap_before_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_q.done |-> ($past(seq_q.cs_n, 1) && $past(seq_q.cs_n, 2)));
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int unsigned SCK_HALF_DIV = 2
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        reg_we_i,
    input  logic [1:0]  reg_addr_i,
    input  logic [31:0] reg_wdata_i,
    output logic [31:0] reg_rdata_o,
    output logic        spi_sck_o,
    output logic        spi_cs_no,
    output logic        spi_mosi_o,
    input  logic        spi_miso_i,
    output logic        done_o
);
    logic [WORD_W-1:0] cmd_w, data_w, rx_word_w;
    logic [TXC_W-1:0]  tx_cnt_w;
    logic [RXC_W-1:0]  rx_cnt_w;
    logic              start_w, busy_w, tick_w, rx_load_w;

    spi_cmd_regs u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_i      (reg_we_i),
        .addr_i    (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .rdata_o   (reg_rdata_o),
        .busy_i    (busy_w),
        .rx_load_i (rx_load_w),
        .rx_word_i (rx_word_w),
        .cmd_o     (cmd_w),
        .data_o    (data_w),
        .tx_cnt_o  (tx_cnt_w),
        .rx_cnt_o  (rx_cnt_w),
        .start_o   (start_w)
    );

    spi_cmd_tick #(.HALF_DIV(SCK_HALF_DIV)) u_tick (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .active_i (busy_w),
        .tick_o   (tick_w)
    );

    spi_cmd_seq u_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start_w),
        .tick_i    (tick_w),
        .tx_cnt_i  (tx_cnt_w),
        .rx_cnt_i  (rx_cnt_w),
        .cmd_i     (cmd_w),
        .data_i    (data_w),
        .miso_i    (spi_miso_i),
        .busy_o    (busy_w),
        .sck_o     (spi_sck_o),
        .cs_n_o    (spi_cs_no),
        .mosi_o    (spi_mosi_o),
        .done_o    (done_o),
        .rx_load_o (rx_load_w),
        .rx_word_o (rx_word_w)
    );
endmodule

// File: tb/spi_cmd_engine_tb_top.sv
module spi_cmd_engine_tb_top;
    localparam int D = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic        miso = 1'b0;
    logic [31:0] rdata;
    logic        sck, cs_n, mosi, done;

    always #10 clk = ~clk;

    spi_cmd_engine #(.SCK_HALF_DIV(D)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .spi_sck_o(sck),
        .spi_cs_no(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso), .done_o(done)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit          m_act = 1'b0;
    bit          m_done = 1'b0;
    int          m_t = 0;
    int          m_tx = 0;
    int          m_rx = 0;
    logic [31:0] m_cmd = '0;
    logic [31:0] m_data = '0;
    bit          m_bits[$];
    logic [7:0]  rx_src[4];

    function automatic int frame_bits();
        return (m_tx + m_rx) * 8;
    endfunction

    function automatic bit in_frame();
        return m_act && (m_t < 2 * frame_bits() * D);
    endfunction

    function automatic logic [31:0] exp_rdata(input logic [1:0] a);
        logic [31:0] r;
        r = '0;
        case (a)
            2'd0: r = m_cmd;
            2'd1: r = m_data;
            2'd2: begin
                r[3:0]  = 4'(m_tx);
                r[6:4]  = 3'(m_rx);
                r[31]   = m_act;
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_done = 0; m_t = 0; m_tx = 0; m_rx = 0;
            m_cmd = '0; m_data = '0; m_bits.delete();
        end else begin
            m_done = 0;
            if (!m_act) begin
                if (we) begin
                    if (addr == 2'd0) m_cmd = wdata;
                    else if (addr == 2'd1) m_data = wdata;
                    else if (addr == 2'd2 && wdata[8]) begin
                        m_tx = int'(wdata[3:0]);
                        if (m_tx == 0) m_tx = 1;
                        if (m_tx > 8) m_tx = 8;
                        m_rx = int'(wdata[6:4]);
                        if (m_rx > 4) m_rx = 4;
                        m_bits.delete();
                        for (int k = 0; k < m_tx; k++) begin
                            logic [7:0] b;
                            if (k == 0) b = m_cmd[7:0];
                            else if (k < 4) b = m_cmd[8*(4-k) +: 8];
                            else b = m_data[8*(k-4) +: 8];
                            for (int i = 7; i >= 0; i--) m_bits.push_back(b[i]);
                        end
                        m_act = 1; m_t = 0;
                    end
                end
            end else begin
                m_t++;
                if (m_t == 2 * frame_bits() * D + 2 * D) begin
                    m_act = 0;
                    m_done = 1;
                    if (m_rx > 0) begin
                        m_data = '0;
                        for (int j = 0; j < m_rx; j++) m_data[8*j +: 8] = rx_src[j];
                    end
                end
            end
        end
    end

    // MISO driven on falling clock edges, stable across the sampling edge
    always @(negedge clk) begin
        int b, r;
        miso = 1'b0;
        if (in_frame()) begin
            b = m_t / (2 * D);
            if (b >= m_tx * 8) begin
                r = b - m_tx * 8;
                miso = rx_src[r / 8][7 - (r % 8)];
            end
        end
    end

    // per-cycle comparison, a quarter period after every rising edge
    always @(posedge clk) begin
        #5;
        if (!finished) begin
            logic exp_sck, exp_mosi;
            int b;
            b = m_t / (2 * D);
            exp_sck  = in_frame() && ((m_t % (2 * D)) >= D);
            exp_mosi = (in_frame() && b < m_tx * 8) ? m_bits[b] : 1'b0;
            chk(cs_n == !in_frame(), "R3 cs_n", 32'(cs_n), 32'(!in_frame()));
            chk(sck == exp_sck, "R3 sck", 32'(sck), 32'(exp_sck));
            chk(mosi == exp_mosi, "R4 mosi", 32'(mosi), 32'(exp_mosi));
            chk(done == m_done, "R9 done", 32'(done), 32'(m_done));
            chk(rdata == exp_rdata(addr), "R2 rdata", rdata, exp_rdata(addr));
        end
    end

    // ---------------- stimulus ----------------
    task automatic write_reg(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic read_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        chk(rdata === exp, tag, rdata, exp);
    endtask

    task automatic wait_frame();
        int guard = 0;
        while (m_act && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        rx_src = '{8'h00, 8'h00, 8'h00, 8'h00};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #1;
        chk(cs_n === 1'b1 && sck === 1'b0 && mosi === 1'b0 && done === 1'b0, "R1 pins", {28'b0, cs_n, sck, mosi, done}, 32'h8);
        read_chk(2'd0, 32'h0, "R1 cmd");
        read_chk(2'd1, 32'h0, "R1 data");
        read_chk(2'd2, 32'h0, "R1 ctrl");

        // full frame: 4 tx, 4 rx; writes during busy are dropped (R7)
        rx_src = '{8'h5A, 8'hC3, 8'h01, 8'hFF};
        write_reg(2'd0, 32'hABCDEF03);
        write_reg(2'd1, 32'h11223344);
        write_reg(2'd2, 32'h00000144);
        read_chk(2'd2, 32'h80000044, "R2 busy readback");
        write_reg(2'd0, 32'h00000000);
        write_reg(2'd2, 32'h00000118);
        wait_frame();
        read_chk(2'd1, 32'hFF01C35A, "R5 rx packing");
        read_chk(2'd0, 32'hABCDEF03, "R7 cmd kept");
        read_chk(2'd2, 32'h00000044, "R7 counts kept");

        // R8 control write without start
        write_reg(2'd2, 32'h00000023);
        read_chk(2'd2, 32'h00000044, "R8 counts kept");

        // eight transmit bytes, no receive: data unchanged (R5)
        write_reg(2'd1, 32'h87654321);
        write_reg(2'd0, 32'h00F00D02);
        write_reg(2'd2, 32'h00000108);
        wait_frame();
        read_chk(2'd1, 32'h87654321, "R5 data unchanged");
        read_chk(2'd2, 32'h00000008, "R2 ctrl readback");

        // R6 clamp tx 0->1, rx 7->4
        rx_src = '{8'hA5, 8'h3C, 8'h96, 8'h0F};
        write_reg(2'd2, 32'h00000170);
        read_chk(2'd2, 32'h80000041, "R6 clamp low");
        wait_frame();
        read_chk(2'd1, 32'h0F963CA5, "R5 rx after clamp");

        // R6 clamp tx 15->8
        write_reg(2'd2, 32'h0000010F);
        wait_frame();
        read_chk(2'd2, 32'h00000008, "R6 clamp high");

        // partial receive: 1 tx, 2 rx
        rx_src = '{8'h81, 8'h7E, 8'hEE, 8'hEE};
        write_reg(2'd0, 32'h00000005);
        write_reg(2'd2, 32'h00000121);
        wait_frame();
        read_chk(2'd1, 32'h00007E81, "R5 partial rx");

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule